// File: doc/BRIEF.md
# Basic-access downstream frame assembler

This block assembles the 48-symbol network-to-subscriber frame of an ISDN basic-access S/T line and emits it as pseudo-ternary symbols. The symbols leave on a two-wire code: one wire for a positive pulse, one for a negative pulse, and neither for no pulse. One frame lasts 250 µs, so the line runs at 192 kbit/s. Each frame carries two B1 octets and two B2 octets, which is 144 kbit/s of user data together with four D-channel bits. Echo, activation, auxiliary-framing, multiframe and subchannel bits sit between the B and D fields. A new symbol starts every `DIV` clock cycles. A one-cycle strobe marks the start of each symbol, and a frame marker is high for the whole of the framing symbol.

All payload and control inputs are captured once per frame, at the edge where the framing symbol begins. The surrounding logic can therefore update them at any time during a frame without tearing it. The framing symbol is a pulse that breaks the alternation rule. Two balancing symbols keep the number of pulses even, so the line stays free of DC.

Top module: `dnf_frame_tx`

## Requirements
- R1: While rst_ni is low, and until the first symbol strobe after reset, line_pos_o, line_neg_o, bit_stb_o and frame_o are all 0.
- R2: bit_stb_o is high for one clock cycle every DIV cycles. Every symbol output holds its value between strobes. frame_o is 1 only during symbol 0 of each 48-symbol frame.
- R3: Symbols 0..47 are sent in this order: F, L, B1 first octet (8), E, D, A, FA, N, B2 first octet (8), E, D, M, B1 second octet (8), E, D, S, B2 second octet (8), E, D, L. A is act_i, M is mf_i and S is sub_i.
- R4: The first B1 octet is b1_i[15:8] and the second is b1_i[7:0]. The same split applies to b2_i. Every octet goes out MSB first. The four D symbols carry d_i[3], d_i[2], d_i[1], d_i[0] in frame order.
- R5: FA carries aux_fa_i, and the N symbol carries its complement.
- R6: The four E symbols carry echo_i[3] down to echo_i[0] in frame order. While echo_force_i is 1, all four E symbols carry echo_force_val_i instead.
- R7: Binary 1 is sent as no pulse (both wires 0), and binary 0 as a pulse on exactly one wire. Outside the framing symbol, each pulse has the opposite polarity to the previous pulse. line_pos_o and line_neg_o are never both 1.
- R8: The framing symbol is always a pulse with the same polarity as the previous pulse (a code violation). The first framing symbol after reset is negative.
- R9: Each L symbol makes the count of binary zeros even over the symbols that follow the previous L, up to and including itself. The framing symbol counts as a zero.
- R10: All payload and control inputs are sampled once, at the start of the framing symbol. Changes made during a frame appear only in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| b1_i | input | 16 | Two B1 octets, first in [15:8] |
| b2_i | input | 16 | Two B2 octets, first in [15:8] |
| d_i | input | 4 | D-channel bits, [3] sent first |
| echo_i | input | 4 | Echo bits, [3] sent first |
| echo_force_i | input | 1 | Replace all echo bits with echo_force_val_i |
| echo_force_val_i | input | 1 | Forced echo value (available/blocked) |
| act_i | input | 1 | Activation bit value |
| aux_fa_i | input | 1 | Auxiliary framing bit value |
| mf_i | input | 1 | Multiframing bit value |
| sub_i | input | 1 | Subchannel bit value |
| line_pos_o | output | 1 | Positive pulse on the line |
| line_neg_o | output | 1 | Negative pulse on the line |
| bit_stb_o | output | 1 | One-cycle strobe at each symbol start |
| frame_o | output | 1 | High during the framing symbol |

## Verification
The hardest case to reach is the capture boundary. An input change that lands in the middle of a frame must not affect that frame, but must affect the next one. The bench counts symbol strobes and rewrites b1_i and the control inputs while symbol 20 is on the line. It then checks the rest of that frame against the old values and the following frame against the new ones. Polarity is also hard to check, because the violation and balancing rules depend on every earlier pulse. For this reason the bench feeds all-zero, all-one and mixed payloads through one continuous run and keeps a polarity model that carries over from frame to frame.

// File: rtl/dnf_pkg.sv
package dnf_pkg;
  localparam int unsigned FRAME_BITS = 48;
  localparam int unsigned SLOT_W     = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    SYM_DATA  = 2'd0,
    SYM_FRAME = 2'd1,
    SYM_BAL   = 2'd2
  } sym_kind_e;

  typedef struct packed {
    logic [15:0] b1;
    logic [15:0] b2;
    logic [3:0]  d;
    logic [3:0]  e;
    logic        a;
    logic        fa;
    logic        m;
    logic        s;
  } frame_src_t;
endpackage

// File: rtl/dnf_timer.sv
module dnf_timer
  import dnf_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              tick_o,
  output logic [SLOT_W-1:0] slot_nxt_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0]     div_q;
  logic [SLOT_W-1:0] slot_q;

  assign tick_o     = (div_q == DW'(DIV - 1));
  assign slot_nxt_o = (slot_q == SLOT_W'(FRAME_BITS - 1)) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      slot_q <= SLOT_W'(FRAME_BITS - 1);
    end else if (tick_o) begin
      div_q  <= '0;
      slot_q <= slot_nxt_o;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/dnf_slot_mux.sv
module dnf_slot_mux
  import dnf_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  input  frame_src_t        src_i,
  output sym_kind_e         kind_o,
  output logic              bit_o
);
  always_comb begin
    kind_o = SYM_DATA;
    bit_o  = 1'b1;
    if (slot_i == 6'd0) begin
      kind_o = SYM_FRAME;
    end else if (slot_i == 6'd1 || slot_i == 6'd47) begin
      kind_o = SYM_BAL;
    end else if (slot_i >= 6'd2 && slot_i <= 6'd9) begin
      bit_o = src_i.b1[4'(6'd17 - slot_i)];
    end else if (slot_i >= 6'd15 && slot_i <= 6'd22) begin
      bit_o = src_i.b2[4'(6'd30 - slot_i)];
    end else if (slot_i >= 6'd26 && slot_i <= 6'd33) begin
      bit_o = src_i.b1[4'(6'd33 - slot_i)];
    end else if (slot_i >= 6'd37 && slot_i <= 6'd44) begin
      bit_o = src_i.b2[4'(6'd44 - slot_i)];
    end else begin
      unique case (slot_i)
        6'd10: bit_o = src_i.e[3];
        6'd23: bit_o = src_i.e[2];
        6'd34: bit_o = src_i.e[1];
        6'd45: bit_o = src_i.e[0];
        6'd11: bit_o = src_i.d[3];
        6'd24: bit_o = src_i.d[2];
        6'd35: bit_o = src_i.d[1];
        6'd46: bit_o = src_i.d[0];
        6'd12: bit_o = src_i.a;
        6'd13: bit_o = src_i.fa;
        6'd14: bit_o = ~src_i.fa;
        6'd25: bit_o = src_i.m;
        6'd36: bit_o = src_i.s;
        default: bit_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dnf_line_coder.sv
module dnf_line_coder
  import dnf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  sym_kind_e kind_i,
  input  logic      bit_i,
  output logic      pos_o,
  output logic      neg_o,
  output logic      stb_o,
  output logic      frame_o
);
  logic last_pos_q;  // polarity of most recent pulse
  logic par_q;       // odd zero count since last L

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
      stb_o      <= 1'b0;
      frame_o    <= 1'b0;
      last_pos_q <= 1'b0;
      par_q      <= 1'b0;
    end else begin
      stb_o <= tick_i;
      if (tick_i) begin
        frame_o <= (kind_i == SYM_FRAME);
        unique case (kind_i)
          SYM_FRAME: begin
            // violation: repeat previous polarity
            pos_o <= last_pos_q;
            neg_o <= ~last_pos_q;
            par_q <= 1'b1;
          end
          SYM_BAL: begin
            if (par_q) begin
              pos_o      <= ~last_pos_q;
              neg_o      <= last_pos_q;
              last_pos_q <= ~last_pos_q;
            end else begin
              pos_o <= 1'b0;
              neg_o <= 1'b0;
            end
            par_q <= 1'b0;
          end
          default: begin
            if (!bit_i) begin
              pos_o      <= ~last_pos_q;
              neg_o      <= last_pos_q;
              last_pos_q <= ~last_pos_q;
              par_q      <= ~par_q;
            end else begin
              pos_o <= 1'b0;
              neg_o <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dnf_frame_tx.sv
module dnf_frame_tx
  import dnf_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] b1_i,
  input  logic [15:0] b2_i,
  input  logic [3:0]  d_i,
  input  logic [3:0]  echo_i,
  input  logic        echo_force_i,
  input  logic        echo_force_val_i,
  input  logic        act_i,
  input  logic        aux_fa_i,
  input  logic        mf_i,
  input  logic        sub_i,
  output logic        line_pos_o,
  output logic        line_neg_o,
  output logic        bit_stb_o,
  output logic        frame_o
);
  logic              tick;
  logic [SLOT_W-1:0] slot_nxt;
  frame_src_t        src_q;
  frame_src_t        src_d;
  sym_kind_e         kind;
  logic              sym_bit;

  dnf_timer #(.DIV(DIV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick),
    .slot_nxt_o (slot_nxt)
  );

  always_comb begin
    src_d.b1 = b1_i;
    src_d.b2 = b2_i;
    src_d.d  = d_i;
    src_d.e  = echo_force_i ? {4{echo_force_val_i}} : echo_i;
    src_d.a  = act_i;
    src_d.fa = aux_fa_i;
    src_d.m  = mf_i;
    src_d.s  = sub_i;
  end

  // capture once per frame, as the F symbol starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      src_q <= '1;
    else if (tick && slot_nxt == '0)  src_q <= src_d;
  end

  dnf_slot_mux u_mux (
    .slot_i (slot_nxt),
    .src_i  (src_q),
    .kind_o (kind),
    .bit_o  (sym_bit)
  );

  dnf_line_coder u_coder (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .kind_i  (kind),
    .bit_i   (sym_bit),
    .pos_o   (line_pos_o),
    .neg_o   (line_neg_o),
    .stb_o   (bit_stb_o),
    .frame_o (frame_o)
  );
endmodule

// File: rtl/dnf_frame_tx_chk.sv
module dnf_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_pos_o,
  input logic line_neg_o,
  input logic bit_stb_o,
  input logic frame_o
);
  logic seen_pos_q;  // polarity of last pulse seen at the ports

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   seen_pos_q <= 1'b0;
    else if (bit_stb_o && (line_pos_o || line_neg_o)) seen_pos_q <= line_pos_o;
  end

  p_no_dual_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_pos_o && line_neg_o));

  p_stb_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_o |-> ($stable(line_pos_o) && $stable(line_neg_o) && $stable(frame_o)));

  p_frame_at_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> bit_stb_o);

  p_violation_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_o && frame_o) |-> ((line_pos_o || line_neg_o) && line_pos_o == seen_pos_q));

  p_alternate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_o && !frame_o && (line_pos_o || line_neg_o)) |-> (line_pos_o != seen_pos_q));
endmodule

bind dnf_frame_tx dnf_frame_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_pos_o (line_pos_o),
  .line_neg_o (line_neg_o),
  .bit_stb_o  (bit_stb_o),
  .frame_o    (frame_o)
);

// File: tb/sim_dnf_frame_tx.sv
module sim_dnf_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] b1_i = '0, b2_i = '0;
  logic [3:0]  d_i = '0, echo_i = '0;
  logic        echo_force_i = 1'b0, echo_force_val_i = 1'b0;
  logic        act_i = 1'b0, aux_fa_i = 1'b0, mf_i = 1'b0, sub_i = 1'b0;
  logic        line_pos_o, line_neg_o, bit_stb_o, frame_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [47:0] mbits;
  int          mkind [48];   // 0 data, 1 F, 2 L
  int          mpos;
  logic        m_last_pos = 1'b0;
  int          m_zeros = 0;
  bit          first_sym = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dnf_frame_tx #(.DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .b1_i(b1_i), .b2_i(b2_i), .d_i(d_i),
    .echo_i(echo_i), .echo_force_i(echo_force_i), .echo_force_val_i(echo_force_val_i),
    .act_i(act_i), .aux_fa_i(aux_fa_i), .mf_i(mf_i), .sub_i(sub_i),
    .line_pos_o(line_pos_o), .line_neg_o(line_neg_o),
    .bit_stb_o(bit_stb_o), .frame_o(frame_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic b);
    mkind[mpos] = kind;
    mbits[47 - mpos] = b;
    mpos++;
  endtask

  task automatic push_octet(input logic [7:0] o);
    for (int i = 7; i >= 0; i--) push(0, o[i]);
  endtask

  // build expected binary frame from current inputs (R3..R6)
  task automatic build_model();
    logic [3:0] e;
    e = echo_force_i ? {4{echo_force_val_i}} : echo_i;
    mpos = 0;
    push(1, 1'b0); push(2, 1'b0);
    push_octet(b1_i[15:8]); push(0, e[3]); push(0, d_i[3]);
    push(0, act_i); push(0, aux_fa_i); push(0, ~aux_fa_i);
    push_octet(b2_i[15:8]); push(0, e[2]); push(0, d_i[2]); push(0, mf_i);
    push_octet(b1_i[7:0]); push(0, e[1]); push(0, d_i[1]); push(0, sub_i);
    push_octet(b2_i[7:0]); push(0, e[0]); push(0, d_i[0]); push(2, 1'b0);
  endtask

  function automatic string req_of(input int s);
    if (s == 0) return "R8";
    if (s == 1 || s == 47) return "R9";
    if (s == 14 || s == 13) return "R5";
    if (s == 10 || s == 23 || s == 34 || s == 45) return "R6";
    if ((s >= 2 && s <= 9) || (s >= 15 && s <= 22) || (s >= 26 && s <= 33) ||
        (s >= 37 && s <= 44)) return "R4";
    return "R3";
  endfunction

  // wait for next symbol, check its spacing (R2)
  task automatic next_sym();
    int cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bit_stb_o);
    if (!first_sym) check(cyc == DIV, "R2", "strobe spacing", cyc, DIV);
    first_sym = 1'b0;
  endtask

  // send one frame, comparing each symbol; optional mid-frame change at symbol 20
  task automatic run_frame(input string name, input bit change_mid,
                           input logic [15:0] new_b1);
    logic exp_p, exp_n, b;
    build_model();
    for (int s = 0; s < 48; s++) begin
      next_sym();
      if (change_mid && s == 20) begin
        b1_i = new_b1; aux_fa_i = ~aux_fa_i; echo_force_i = ~echo_force_i;
      end
      b = mbits[47 - s];
      if (mkind[s] == 1) begin
        exp_p = m_last_pos; exp_n = ~m_last_pos;
        m_zeros = 1;
      end else begin
        if (mkind[s] == 2) b = (m_zeros % 2 == 0);
        if (!b) begin
          exp_p = ~m_last_pos; exp_n = m_last_pos; m_last_pos = ~m_last_pos;
          m_zeros++;
        end else begin
          exp_p = 1'b0; exp_n = 1'b0;
        end
        if (mkind[s] == 2) m_zeros = 0;
      end
      check(frame_o == (s == 0), "R2", $sformatf("%s frame_o slot %0d", name, s),
            frame_o, s == 0);
      check(!(line_pos_o && line_neg_o), "R7", $sformatf("%s dual pulse slot %0d", name, s),
            {line_pos_o, line_neg_o}, 0);
      check({line_pos_o, line_neg_o} == {exp_p, exp_n},
            change_mid ? "R10" : req_of(s),
            $sformatf("%s symbol slot %0d", name, s),
            {line_pos_o, line_neg_o}, {exp_p, exp_n});
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check({line_pos_o, line_neg_o, bit_stb_o, frame_o} == 4'b0, "R1", "outputs in reset",
          {line_pos_o, line_neg_o, bit_stb_o, frame_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({line_pos_o, line_neg_o, bit_stb_o, frame_o} == 4'b0, "R1", "outputs after reset",
          {line_pos_o, line_neg_o, bit_stb_o, frame_o}, 0);
  endtask

  task automatic set_in(input logic [15:0] b1, input logic [15:0] b2, input logic [3:0] d,
                        input logic [3:0] e, input logic ef, input logic ev,
                        input logic a, input logic fa, input logic m, input logic s);
    b1_i = b1; b2_i = b2; d_i = d; echo_i = e; echo_force_i = ef; echo_force_val_i = ev;
    act_i = a; aux_fa_i = fa; mf_i = m; sub_i = s;
  endtask

  task automatic t_mixed();
    set_in(16'hA55A, 16'h3C81, 4'b1010, 4'b0110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    run_frame("mixed", 1'b0, '0);
  endtask

  task automatic t_zeros();
    set_in(16'h0000, 16'h0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_frame("zeros", 1'b0, '0);
  endtask

  task automatic t_ones();
    set_in(16'hFFFF, 16'hFFFF, 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    run_frame("ones", 1'b0, '0);
  endtask

  task automatic t_echo_force();
    set_in(16'h1234, 16'hFEDC, 4'b0011, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_frame("echo_force0", 1'b0, '0);
    set_in(16'h8001, 16'h7FFE, 4'b1100, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_frame("echo_force1", 1'b0, '0);
  endtask

  task automatic t_mid_change();
    set_in(16'h00FF, 16'h0F0F, 4'b0101, 4'b1001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("mid_change", 1'b1, 16'hC3E7);
    run_frame("after_change", 1'b0, '0);
  endtask

  initial begin
    set_in(16'hA55A, 16'h3C81, 4'b1010, 4'b0110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    t_reset();
    t_mixed();
    t_zeros();
    t_ones();
    t_echo_force();
    t_mid_change();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule